// File: doc/BRIEF.md
# Ethernet Frame IV Inserter

This block is a store-and-forward stage on a 37-bit streaming bus that places a 16-byte initialization vector inside every frame routed to it for encryption. The vector lands directly after the 14-byte MAC header, which is made of two 6-byte addresses and the 2-byte type field. A following stage can then encrypt the payload with a keystream derived from that vector. Frames that need no encryption are switched around this block elsewhere and never reach it.

Each incoming frame is written whole into a word RAM, and its byte length is pushed into a small length queue. When a complete frame is waiting, the block takes one vector from a side port through a valid/ready handshake. It then replays the frame with the vector spliced in and reports the new length beside the data. Inputs are 14 to `MAX_BYTES` bytes long. Outputs grow by 16 bytes, so they may pass the usual size limit. They are forwarded anyway, so that a later stage can split them.

Top module: `ivins_top`

## Requirements
- R1: While reset is held and right after it is released, the output valid bit (bit 32) is 0, `iv_ready` is 0 and `in_ready` is 1.
- R2: A stream word packs start-of-frame in bit 36, end-of-frame in bit 35, the empty-byte count in bits 34:33, valid in bit 32, and four frame bytes in bits 31:0 with the earliest byte in bits 31:24. Output words 0 to 2 equal input words 0 to 2. Output word 3 holds input bytes 12 and 13 followed by IV bytes 0 and 1, where IV byte 0 is `iv_data[127:120]`.
- R3: Output words 4, 5 and 6 carry IV bytes 2 to 13 in order. Output word 7 holds IV bytes 14 and 15 followed by input bytes 14 and 15.
- R4: Every output word k from 8 on equals input word k-4, so the payload after byte 15 keeps its order and word alignment.
- R5: For an input of L bytes, the output frame has ceil((L+16)/4) words. Start-of-frame is set only on the first word and end-of-frame only on the last. The last word's empty count is (4-(L+16) mod 4) mod 4, and every other word's is 0. `out_len` shows L+16 on every word of the frame.
- R6: `iv_ready` is high only between output frames while a complete frame is stored. One vector is taken per frame, in arrival order. No word of a frame is sent before its vector has been accepted.
- R7: At a frame boundary, `in_ready` is low when the RAM has fewer free words than ceil(`MAX_BYTES`/4), or when `LEN_DEPTH` frames are already queued. Inside a frame it stays high.
- R8: A maximum-size input of `MAX_BYTES` (1518) bytes is forwarded whole as 1534 bytes in 384 words.
- R9: While the output valid bit is set and `out_ready` is low, `out_word` and `out_len` hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_word | input | 37 | Input stream word: sideband bits 36:32, data bits 31:0 |
| in_ready | output | 1 | Input word accepted when valid bit and this are both high |
| iv_valid | input | 1 | Initialization vector offered |
| iv_data | input | 128 | Initialization vector, byte 0 in the top bits |
| iv_ready | output | 1 | Vector taken when valid and this are both high |
| out_word | output | 37 | Output stream word, same layout as the input |
| out_ready | input | 1 | Downstream accepts the current output word |
| out_len | output | LEN_W | Byte length of the frame being sent, vector included |

## Verification
Frames of 14 to 19 bytes test the splice where the header ends mid-word and the payload is shorter than one word. They separate a correct word 7 and empty count from an off-by-half-word realignment. Random lengths up to 1518 bytes, with random input gaps, vector delays and output stalls, compare every output word against a model built from the frame bytes. This shows the tail words keep their order and that stalls neither drop nor repeat a word. Held-back vectors prove no word leaves early. Blocked output with no vectors, fed first with short frames and then with maximum-size frames, shows which limit (length queue or RAM space) drops `in_ready`.

// File: rtl/ivins_pkg.sv
`timescale 1ns/1ps
package ivins_pkg;
   localparam int DATA_W = 32;
   localparam int SIDE_W = 5;
   localparam int WORD_W = DATA_W + SIDE_W;
   localparam int IV_W   = 128;
   localparam int HDR_W  = 4;   // words before the splice point

   typedef struct packed {
      logic              sop;
      logic              eop;
      logic [1:0]        empty;
      logic              vld;
      logic [DATA_W-1:0] data;
   } sbeat_t;
endpackage

// File: rtl/ivins_lenq.sv
`timescale 1ns/1ps
module ivins_lenq #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;

   generate
      if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("ivins_lenq: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
endmodule

// File: rtl/ivins_store.sv
`timescale 1ns/1ps
module ivins_store
   import ivins_pkg::*;
#(
   parameter int DEPTH     = 1024,
   parameter int LEN_W     = 16,
   parameter int MAX_WORDS = 380,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic              rel,
   input  logic [AW:0]       rel_words,
   output logic              len_push,
   output logic [LEN_W-1:0]  len_data,
   input  logic              len_full
);
   sbeat_t           beat;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]    wp;
   logic [AW:0]      used, free_w;
   logic [LEN_W-1:0] wcnt, nwords;
   logic             mid, take, space_ok;

   assign beat     = sbeat_t'(in_word);
   assign free_w   = (AW+1)'(DEPTH) - used;
   assign space_ok = (free_w >= (AW+1)'(MAX_WORDS));
   assign in_ready = mid || (space_ok && !len_full);
   assign take     = beat.vld && in_ready;
   assign nwords   = beat.sop ? LEN_W'(1) : wcnt + LEN_W'(1);
   assign len_push = take && beat.eop;
   assign len_data = (nwords << 2) - LEN_W'(beat.empty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         used <= '0;
         wcnt <= '0;
         mid  <= 1'b0;
      end else begin
         used <= used + {{AW{1'b0}}, take} - (rel ? rel_words : '0);
         if (take) begin
            wp   <= wp + 1'b1;
            wcnt <= nwords;
            mid  <= !beat.eop;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) mem[wp] <= beat.data;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ivins_replay.sv
`timescale 1ns/1ps
module ivins_replay
   import ivins_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_empty,
   input  logic [LEN_W-1:0]  len_head,
   output logic              len_pop,
   input  logic              iv_valid,
   input  logic [IV_W-1:0]   iv_data,
   output logic              iv_ready,
   output logic [AW-1:0]     raddr,
   input  logic [DATA_W-1:0] rdata,
   output logic              rel,
   output logic [AW:0]       rel_words,
   output logic [WORD_W-1:0] out_word,
   input  logic              out_ready,
   output logic [LEN_W-1:0]  out_len
);
   typedef enum logic {RP_IDLE, RP_SEND} rp_state_e;

   rp_state_e        st;
   logic [LEN_W-1:0] len_q, k, in_words, widx;
   logic [IV_W-1:0]  iv_q;
   logic [AW-1:0]    base;
   logic             last;
   sbeat_t           beat;

   assign in_words  = (len_q + LEN_W'(3)) >> 2;
   assign last      = (k == in_words + LEN_W'(HDR_W - 1));
   assign iv_ready  = (st == RP_IDLE) && !len_empty;
   assign len_pop   = iv_ready && iv_valid;
   assign rel       = (st == RP_SEND) && out_ready && last;
   assign rel_words = in_words[AW:0];
   assign out_len   = (st == RP_SEND) ? len_q + LEN_W'(16) : '0;

   // stored word feeding output word k
   always_comb begin
      if (k < LEN_W'(HDR_W))          widx = k;
      else if (k < LEN_W'(2*HDR_W))   widx = LEN_W'(HDR_W - 1);
      else                            widx = k - LEN_W'(HDR_W);
   end
   assign raddr = base + widx[AW-1:0];

   always_comb begin
      beat = '0;
      if (st == RP_SEND) begin
         beat.vld   = 1'b1;
         beat.sop   = (k == '0);
         beat.eop   = last;
         beat.empty = last ? (~len_q[1:0] + 2'd1) : 2'b00;
         if (k == LEN_W'(3))      beat.data = {rdata[31:16], iv_q[127:112]};
         else if (k == LEN_W'(4)) beat.data = iv_q[111:80];
         else if (k == LEN_W'(5)) beat.data = iv_q[79:48];
         else if (k == LEN_W'(6)) beat.data = iv_q[47:16];
         else if (k == LEN_W'(7)) beat.data = {iv_q[15:0], rdata[15:0]};
         else                     beat.data = rdata;
      end
   end
   assign out_word = beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RP_IDLE;
         k     <= '0;
         len_q <= '0;
         iv_q  <= '0;
         base  <= '0;
      end else begin
         case (st)
            RP_IDLE: begin
               if (len_pop) begin
                  len_q <= len_head;
                  iv_q  <= iv_data;
                  k     <= '0;
                  st    <= RP_SEND;
               end
            end
            default: begin
               if (out_ready) begin
                  if (last) begin
                     st   <= RP_IDLE;
                     base <= base + in_words[AW-1:0];
                  end else begin
                     k <= k + LEN_W'(1);
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/ivins_top.sv
`timescale 1ns/1ps
module ivins_top
   import ivins_pkg::*;
#(
   parameter int DEPTH     = 1024,
   parameter int LEN_DEPTH = 4,
   parameter int MAX_BYTES = 1518,
   parameter int LEN_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [36:0]       in_word,
   output logic              in_ready,
   input  logic              iv_valid,
   input  logic [127:0]      iv_data,
   output logic              iv_ready,
   output logic [36:0]       out_word,
   input  logic              out_ready,
   output logic [LEN_W-1:0]  out_len
);
   localparam int AW        = $clog2(DEPTH);
   localparam int MAX_WORDS = (MAX_BYTES + 3) / 4;

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("ivins_top: DEPTH must be a power of two");
      end
      if (DEPTH < MAX_WORDS) begin : g_small_ram
         $error("ivins_top: DEPTH cannot hold one maximum frame");
      end
      if ((1 << LEN_W) <= MAX_BYTES + 16) begin : g_short_len
         $error("ivins_top: LEN_W too narrow for the grown length");
      end
      if (LEN_W <= AW) begin : g_len_vs_addr
         $error("ivins_top: LEN_W must exceed the RAM address width");
      end
   endgenerate

   logic [AW-1:0]     raddr;
   logic [DATA_W-1:0] rdata;
   logic              rel;
   logic [AW:0]       rel_words;
   logic              lf_push, lf_pop, lf_full, lf_empty;
   logic [LEN_W-1:0]  lf_din, lf_dout;

   ivins_store #(
      .DEPTH(DEPTH), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .in_word(in_word), .in_ready(in_ready),
      .raddr(raddr), .rdata(rdata),
      .rel(rel), .rel_words(rel_words),
      .len_push(lf_push), .len_data(lf_din), .len_full(lf_full)
   );

   ivins_lenq #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_lenq (
      .clk(clk), .rst_n(rst_n),
      .push(lf_push), .din(lf_din), .pop(lf_pop),
      .dout(lf_dout), .full(lf_full), .empty(lf_empty)
   );

   ivins_replay #(.AW(AW), .LEN_W(LEN_W)) u_replay (
      .clk(clk), .rst_n(rst_n),
      .len_empty(lf_empty), .len_head(lf_dout), .len_pop(lf_pop),
      .iv_valid(iv_valid), .iv_data(iv_data), .iv_ready(iv_ready),
      .raddr(raddr), .rdata(rdata),
      .rel(rel), .rel_words(rel_words),
      .out_word(out_word), .out_ready(out_ready), .out_len(out_len)
   );
endmodule

// File: rtl/ivins_chk.sv
`timescale 1ns/1ps
module ivins_chk #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [36:0]      in_word,
   input logic             in_ready,
   input logic             iv_valid,
   input logic             iv_ready,
   input logic [36:0]      out_word,
   input logic             out_ready,
   input logic [LEN_W-1:0] out_len,
   input logic             lf_push,
   input logic             lf_full
);
   logic out_in_pkt, in_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_in_pkt <= 1'b0;
         in_mid     <= 1'b0;
      end else begin
         if (out_word[32] && out_ready) out_in_pkt <= !out_word[35];
         if (in_word[32] && in_ready)   in_mid     <= !in_word[35];
      end
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_word[32] && !out_ready |=> $stable(out_word) && $stable(out_len));

   // R6
   iv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iv_ready |-> !out_word[32]);

   // R6
   iv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iv_ready && !iv_valid |=> iv_ready);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lf_full |-> !lf_push);

   // R7
   mid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_mid |-> in_ready);

   // R5
   empty_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_word[32] && !out_word[35] |-> out_word[34:33] == 2'b00);

   // R5
   sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_word[32] && !out_in_pkt |-> out_word[36]);
endmodule

bind ivins_top ivins_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_word(in_word), .in_ready(in_ready),
   .iv_valid(iv_valid), .iv_ready(iv_ready),
   .out_word(out_word), .out_ready(out_ready), .out_len(out_len),
   .lf_push(lf_push), .lf_full(lf_full)
);

// File: tb/ivins_top_tb_top.sv
`timescale 1ns/1ps
module ivins_top_tb_top;
   localparam int DEPTH = 1024, LEN_DEPTH = 4, MAX_BYTES = 1518, LEN_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [36:0]      in_word = '0;
   logic             in_ready;
   logic             iv_valid = 1'b0;
   logic [127:0]     iv_data = '0;
   logic             iv_ready;
   logic [36:0]      out_word;
   logic             out_ready = 1'b0;
   logic [LEN_W-1:0] out_len;

   ivins_top #(.DEPTH(DEPTH), .LEN_DEPTH(LEN_DEPTH), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_ready(in_ready),
      .iv_valid(iv_valid), .iv_data(iv_data), .iv_ready(iv_ready),
      .out_word(out_word), .out_ready(out_ready), .out_len(out_len));

   int checks = 0, errors = 0;
   byte unsigned txb[$], exb[$];
   int txl[$], exl[$];
   logic [127:0] ivq[$], exivq[$];
   bit out_en = 1'b1;
   int rdy_pct = 100, gap_pct = 0;
   int acc_frames = 0, done_frames = 0;
   bit finished = 1'b0;

   byte unsigned cur [2048];
   logic [127:0] civ;
   int cur_len = 0, k = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ivb(input int i);
      return civ[127-8*i -: 8];
   endfunction

   function automatic logic [31:0] exp_data(input int kk);
      int o;
      if (kk == 3) return {cur[12], cur[13], ivb(0), ivb(1)};
      if (kk >= 4 && kk <= 6) begin
         o = (kk - 4) * 4 + 2;
         return {ivb(o), ivb(o+1), ivb(o+2), ivb(o+3)};
      end
      if (kk == 7) return {ivb(14), ivb(15), cur[14], cur[15]};
      o = (kk < 3) ? kk * 4 : (kk - 4) * 4;
      return {cur[o], cur[o+1], cur[o+2], cur[o+3]};
   endfunction

   task automatic add_frame(input int len, input bit incr);
      byte unsigned b;
      for (int i = 0; i < len; i++) begin
         b = incr ? byte'(i + 1) : byte'($urandom_range(255));
         txb.push_back(b);
         exb.push_back(b);
      end
      txl.push_back(len);
      exl.push_back(len);
   endtask

   task automatic add_iv();
      logic [127:0] v;
      v = {$urandom, $urandom, $urandom, $urandom};
      ivq.push_back(v);
      exivq.push_back(v);
   endtask

   // input driver
   task automatic drive_frame();
      int len, nw;
      byte unsigned b[4];
      bit rdy;
      len = txl.pop_front();
      nw = (len + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         while (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
            in_word = '0;
            @(negedge clk);
         end
         for (int j = 0; j < 4; j++) b[j] = (w*4 + j < len) ? txb.pop_front() : 8'h00;
         in_word = {w == 0, w == nw - 1, (w == nw - 1) ? 2'((4 - len % 4) % 4) : 2'b00,
                    1'b1, b[0], b[1], b[2], b[3]};
         rdy = in_ready;
         @(negedge clk);
         while (!rdy) begin
            rdy = in_ready;
            @(negedge clk);
         end
         if (w == nw - 1) acc_frames++;
      end
      in_word = '0;
   endtask

   initial begin
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (txl.size() != 0) drive_frame();
      end
   end

   // vector driver
   initial begin
      bit rdy;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (ivq.size() != 0 && $urandom_range(3) != 0) begin
            iv_data  = ivq.pop_front();
            iv_valid = 1'b1;
            rdy = iv_ready;
            @(negedge clk);
            while (!rdy) begin
               rdy = iv_ready;
               @(negedge clk);
            end
            iv_valid = 1'b0;
         end
      end
   end

   // output monitor
   task automatic take_word(input logic [36:0] w, input logic [LEN_W-1:0] ln);
      int nout;
      string tag;
      logic [3:0] exp_sb;
      if (k == 0) begin
         if (exl.size() == 0 || exivq.size() == 0) begin
            chk(1'b0, "R6", "unexpected output frame", w, 0);
            return;
         end
         cur_len = exl.pop_front();
         civ = exivq.pop_front();
         for (int i = 0; i < 2048; i++) cur[i] = (i < cur_len) ? exb.pop_front() : 8'h00;
         chk(ln == LEN_W'(cur_len + 16), "R5", "out_len", ln, cur_len + 16);
         if (cur_len == MAX_BYTES)
            chk(ln == LEN_W'(MAX_BYTES + 16), "R8", "max frame length", ln, MAX_BYTES + 16);
      end
      nout = (cur_len + 19) / 4;
      tag = (k <= 3) ? "R2" : (k <= 7) ? "R3" : "R4";
      chk(w[31:0] == exp_data(k), tag, $sformatf("data word %0d len %0d", k, cur_len),
          w[31:0], exp_data(k));
      exp_sb = {k == 0, k == nout - 1,
                (k == nout - 1) ? 2'((4 - (cur_len + 16) % 4) % 4) : 2'b00};
      chk(w[36:33] == exp_sb, "R5", $sformatf("sideband word %0d", k), w[36:33], exp_sb);
      if (w[35]) begin
         if (cur_len == MAX_BYTES) chk(k == 383, "R8", "max frame last index", k, 383);
         k = 0;
         done_frames++;
      end else begin
         k++;
      end
   endtask

   initial begin
      bit hold;
      logic [36:0] held_w;
      logic [LEN_W-1:0] held_l;
      hold = 1'b0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (hold) chk(out_word == held_w && out_len == held_l, "R9", "stalled word moved",
                       out_word, held_w);
         out_ready = out_en && ($urandom_range(99) < rdy_pct);
         if (out_word[32]) begin
            hold = !out_ready;
            held_w = out_word;
            held_l = out_len;
            if (out_ready) take_word(out_word, out_len);
         end else begin
            hold = 1'b0;
         end
      end
   end

   task automatic wait_drain();
      int n = 0;
      while ((exl.size() != 0 || k != 0) && n < 40000) begin
         @(negedge clk);
         n++;
      end
      chk(exl.size() == 0 && k == 0, "R6", "frames left undelivered", exl.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int a0, lens[6];
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(out_word[32] == 1'b0, "R1", "valid in reset", out_word[32], 0);
      chk(iv_ready == 1'b0, "R1", "iv_ready in reset", iv_ready, 0);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_word[32] == 1'b0 && iv_ready == 1'b0 && in_ready == 1'b1, "R1",
          "state after reset", {out_word[32], iv_ready, in_ready}, 3'b001);

      // basic directed frame, R2 R3 R4 R5
      add_frame(60, 1'b1);
      add_iv();
      wait_drain();

      // R6: no vector, no output
      add_frame(100, 1'b0);
      repeat (200) @(negedge clk);
      chk(out_word[32] == 1'b0, "R6", "output before vector", out_word[32], 0);
      chk(iv_ready == 1'b1, "R6", "iv_ready with frame stored", iv_ready, 1);
      add_iv();
      wait_drain();

      // R7: length queue limit
      out_en = 1'b0;
      a0 = acc_frames;
      for (int i = 0; i < 6; i++) add_frame(60, 1'b0);
      repeat (400) @(negedge clk);
      chk(acc_frames - a0 == LEN_DEPTH, "R7", "frames taken with queue full", acc_frames - a0, LEN_DEPTH);
      chk(in_ready == 1'b0, "R7", "in_ready with queue full", in_ready, 0);
      for (int i = 0; i < 6; i++) add_iv();
      out_en = 1'b1;
      wait_drain();

      // R7 RAM space limit, R8 max frames
      out_en = 1'b0;
      a0 = acc_frames;
      for (int i = 0; i < 3; i++) add_frame(MAX_BYTES, 1'b0);
      repeat (1200) @(negedge clk);
      chk(acc_frames - a0 == 2, "R7", "max frames taken with RAM short", acc_frames - a0, 2);
      chk(in_ready == 1'b0, "R7", "in_ready with RAM short", in_ready, 0);
      for (int i = 0; i < 3; i++) add_iv();
      out_en = 1'b1;
      wait_drain();

      // short-frame corners and random traffic
      rdy_pct = 70;
      gap_pct = 20;
      lens = '{14, 15, 16, 17, 18, 19};
      foreach (lens[i]) begin
         add_frame(lens[i], 1'b0);
         add_iv();
      end
      for (int i = 0; i < 30; i++) begin
         add_frame($urandom_range(MAX_BYTES, 14), 1'b0);
         add_iv();
      end
      wait_drain();

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule